// File: doc/BRIEF.md
# Single-Slot Zero-Latency Queue

This block is a queue that holds at most one word and never delays a word that finds it empty. A word presented on the write port while the slot is empty appears on the read port in the same cycle. If the reader takes it in that cycle, the word passes straight through and is never stored. If the reader does not take it, the word is captured at the clock edge and offered on every later cycle until it is read.

Within one cycle the operations take effect in a fixed order: the write first, then the head read, then the removal, and the clear last. Because the write comes before the read, an empty queue can accept a word and hand it on in the same cycle. Because the clear comes last, a clear leaves the queue empty whatever else happened in that cycle.

The controller has two named states. EMPTY means no word is held. FULL means one word is held and presented. There are four transitions. EMPTY to FULL (STORE) happens when a write is accepted, is not read and no clear is given. FULL to EMPTY (DRAIN) happens when the held word is read or a clear is given. EMPTY stays EMPTY (PASS) when nothing is written, when a written word passes straight through, or when a clear is given. FULL stays FULL (HOLD) when the held word is not read and no clear is given.

Top module: `bypass_slot_queue`

## Requirements
- R1: After a synchronous active-high reset the queue is empty: `in_ready` is 1, and `out_valid` is 0 while `in_valid` is 0.
- R2: `in_ready` is 1 exactly when the queue is empty. A dequeue in the same cycle does not make a full queue ready.
- R3: When the queue is empty and `in_valid` is 1, `out_valid` is 1 and `out_data` equals `in_data` in that same cycle.
- R4: When the queue is empty and a write and a read happen in the same cycle, the word passes through and the queue is still empty in the next cycle.
- R5: When the queue is empty and a written word is not read (and no clear is given), the word is stored. In the next cycle `out_valid` is 1, `out_data` is that word and `in_ready` is 0.
- R6: While the queue is full, `out_valid` stays 1 and `out_data` stays unchanged until the word is read or cleared.
- R7: When the queue is full and `out_ready` is 1, the held word is removed and the queue is empty in the next cycle.
- R8: A cycle with `clr` at 1 leaves the queue empty in the next cycle, whatever writes or reads happen in the same cycle. Same-cycle pass-through to the output is still shown.
- R9: A write presented while the queue is full is refused and does not change the held word.
- R10: Words leave in the order they were accepted. No word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear, applied after the other operations of the cycle |
| in_valid | input | 1 | Write request |
| in_data | input | WIDTH | Write word |
| in_ready | output | 1 | Queue can accept a write (queue empty) |
| out_valid | output | 1 | A head word is available |
| out_data | output | WIDTH | Head word: the held word if full, otherwise `in_data` |
| out_ready | input | 1 | Reader takes the head word this cycle |

## Verification
The assertions assume that the inputs are steady from a little after one rising edge until the next, and are never unknown outside reset. They do not assume the writer honours `in_ready`, because a refused write is part of the specified behaviour. The bench changes every input only at the falling clock edge. Besides directed cases, it drives random `in_valid`, `out_ready` and occasional `clr`, so that refused writes, pass-through and clear collisions all occur within the same rules.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/bsq_slot_ctl.sv
module bsq_slot_ctl
    import bsq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic wr_fire,
    input  logic rd_fire,
    output logic slot_full,
    output logic store_en
);
    slot_state_e state_q;
    slot_state_e state_d;

    // Next-state logic: the write is applied first, then the read, then the clear.
    always_comb begin
        state_d  = state_q;
        store_en = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (wr_fire && !rd_fire && !clr) begin
                    state_d  = SLOT_FULL;   // STORE
                    store_en = 1'b1;
                end
            end
            SLOT_FULL: begin
                if (rd_fire || clr) begin
                    state_d = SLOT_EMPTY;   // DRAIN
                end
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        slot_full = (state_q == SLOT_FULL);
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> !slot_full); // R8

    AST_READ_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (slot_full && rd_fire) |=> !slot_full); // R7
endmodule

// File: rtl/bsq_word_reg.sv
module bsq_word_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk) begin
        if (load) begin
            word_q <= din;
        end
    end

    always_comb begin
        dout = word_q;
    end
endmodule

// File: rtl/bypass_slot_queue.sv
module bypass_slot_queue #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ready
);
    logic             slot_full;
    logic             store_en;
    logic             wr_fire;
    logic             rd_fire;
    logic [WIDTH-1:0] held_word;

    always_comb begin
        in_ready  = !slot_full;
        wr_fire   = in_valid && in_ready;
        out_valid = slot_full || in_valid;
        out_data  = slot_full ? held_word : in_data;
        rd_fire   = out_valid && out_ready;
    end

    bsq_slot_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .wr_fire  (wr_fire),
        .rd_fire  (rd_fire),
        .slot_full(slot_full),
        .store_en (store_en)
    );

    bsq_word_reg #(.WIDTH(WIDTH)) u_word (
        .clk (clk),
        .load(store_en),
        .din (in_data),
        .dout(held_word)
    );

    AST_PASS_STAYS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid && out_ready) |=> in_ready); // R4

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !clr) |=> (out_valid && out_data == $past(out_data))); // R5

    AST_FULL_PRESENTS: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && in_valid && !out_ready && !clr) |=> (!in_ready && $stable(out_data))); // R9
endmodule

// File: tb/tb_bypass_slot_queue.sv
module tb_bypass_slot_queue;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         clr;
    logic         in_valid;
    logic [W-1:0] in_data;
    logic         in_ready;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         out_ready;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] model_q[$];

    always #4 clk = ~clk;

    bypass_slot_queue #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .clr(clr),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare against the model, advance the model at the rising edge.
    task automatic cycle(input logic iv, input logic [W-1:0] id, input logic ordy, input logic cl, input string tag);
        logic exp_rdy, exp_ov, wr, rd;
        logic [W-1:0] exp_head;
        @(negedge clk);
        in_valid = iv; in_data = id; out_ready = ordy; clr = cl;
        #1;
        exp_rdy  = (model_q.size() == 0);
        exp_ov   = (model_q.size() != 0) || iv;
        exp_head = (model_q.size() != 0) ? model_q[0] : id;
        chk(in_ready == exp_rdy, {tag, " R2 ready"}, W'(in_ready), W'(exp_rdy));
        chk(out_valid == exp_ov, {tag, " R3 valid"}, W'(out_valid), W'(exp_ov));
        if (exp_ov) chk(out_data == exp_head, {tag, " R10 head"}, out_data, exp_head);
        wr = iv && exp_rdy;
        rd = exp_ov && ordy;
        @(posedge clk);
        if (wr) model_q.push_back(id);
        if (rd) void'(model_q.pop_front());
        if (cl) model_q.delete();
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; clr = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R1 ready after reset", W'(in_ready), W'(1));
        chk(out_valid == 1'b0, "R1 idle after reset", W'(out_valid), W'(0));

        cycle(1'b1, 16'hA001, 1'b1, 1'b0, "R3 R4 pass-through");
        cycle(1'b0, 16'h0000, 1'b0, 1'b0, "R4 still empty");
        cycle(1'b1, 16'hB002, 1'b0, 1'b0, "R5 store");
        cycle(1'b1, 16'hC003, 1'b0, 1'b0, "R6 R9 refused write");
        cycle(1'b0, 16'h0000, 1'b0, 1'b0, "R6 hold");
        cycle(1'b1, 16'hD004, 1'b1, 1'b0, "R7 R2 drain with write");
        cycle(1'b0, 16'h0000, 1'b0, 1'b0, "R7 empty after drain");
        cycle(1'b1, 16'hE005, 1'b0, 1'b1, "R8 clear with write");
        cycle(1'b0, 16'h0000, 1'b0, 1'b0, "R8 empty after clear");
        cycle(1'b1, 16'hF006, 1'b0, 1'b0, "R5 store again");
        cycle(1'b0, 16'h0000, 1'b1, 1'b1, "R8 clear with read");
        cycle(1'b0, 16'h0000, 1'b0, 1'b0, "R8 empty");

        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom_range(0, 3) != 0), W'($urandom), ($urandom_range(0, 2) != 0),
                  ($urandom_range(0, 31) == 0), "R10 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule